// File: doc/BRIEF.md
# Serial Clock-Calendar and Battery-RAM Slave

This block is a serial slave that software reaches by writing a control byte over and over. Three bits of that byte matter. One is a select line, one is a serial clock and one is a data line that goes both ways. A frame opens on the first write that has select high. The slave then samples the data bit on every high-to-low step of the clock bit. It finds these steps by comparing each new byte with the byte stored from the previous write. The first eight samples form a command byte and the next eight form a value byte, both MSB first.

During the eight data steps, a read command makes the slave put one bit of the addressed byte onto the data line, MSB first. That bit replaces the data bit in the stored control byte, so software reads it back through the same register. The addressed byte can be a battery-RAM entry, the status byte, the control byte, or a packed-BCD time field taken from the time-of-day inputs. A write command commits on the sixteenth falling step. It either stores the value byte into RAM or clears the two status flags. When it clears the flags it also sends a one-cycle request to the interrupt logic to drop its matching bit. Writing the byte with select low ends or aborts the frame.

Top module: `rtc_serial_slave`

## Requirements
- R1: After reset: `ctrl_o`, `dout_o`, `flag_clr_o` and `rd_shift_o` are zero. The status byte is 0x90. The control byte is `CTRL_INIT`. RAM entry i holds `((i*0x1D) mod 256) XOR 0x5A`.
- R2: Bit 0 of the control byte is select, bit 1 is the serial clock and bit 2 is data. A sample is taken only on a write that has select high and clock bit 0, when the previously stored byte had clock bit 1. A cycle with `wr_en_i` low changes nothing.
- R3: The first write with select high starts the frame at phase 0. Falling steps 1 to 8 shift the data bit into the command byte, MSB first.
- R4: Commands 0x00 to 0x1F read RAM entry `cmd`. On data step k (k = 1 to 8), bit 8-k of the byte is written into bit 2 of the stored byte and appears on `ctrl_o[2]` and `dout_o` one cycle after the write.
- R5: Command 0x30 returns the status byte. Command 0x31 returns the control byte.
- R6: Commands 0x20, 0x21, 0x22, 0x24, 0x25 and 0x26 return, in packed BCD, the seconds, minutes, hours, day of month, `mon_i`+1 and `year_i`-100. The other commands from 0x20 to 0x2F return 0x00.
- R7: Commands 0x80 to 0x9F write the value byte into RAM entry `cmd`-0x80 on the 16th falling step. During the data steps, data bit 2 is reflected unchanged.
- R8: Command 0xB1 with value bit 2 set clears status bits 3 and 4 and raises `flag_clr_o` for exactly one cycle. If value bit 2 is clear, it does neither.
- R9: A write with select low returns the frame to idle and zeroes the command and value bytes. A frame aborted before its 16th step commits nothing.
- R10: Any command outside the ranges above forces bit 2 low during the data steps and commits nothing.
- R11: For read commands, each returned bit is also shifted into `rd_shift_o`, MSB first. For other commands `rd_shift_o` holds its value.
- R12: Falling steps after the 16th do not shift, return or commit anything. Bit 2 is then reflected as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Control-byte write strobe |
| ctrl_i | input | 8 | Control byte being written |
| sec_i | input | 6 | Seconds, binary 0-59 |
| min_i | input | 6 | Minutes, binary 0-59 |
| hour_i | input | 5 | Hours, binary 0-23 |
| mday_i | input | 5 | Day of month, binary 1-31 |
| mon_i | input | 4 | Month index, binary 0-11 |
| year_i | input | 8 | Years since 1900, binary 100-199 |
| ctrl_o | output | 8 | Stored control byte, bit 2 carrying returned data |
| dout_o | output | 1 | Returned data bit (bit 2 of `ctrl_o`) |
| flag_clr_o | output | 1 | One-cycle request to clear interrupt-status bit 2 |
| rd_shift_o | output | 8 | Accumulated returned bits |

## Verification
The bench builds the block with `CTRL_INIT` = 0x6C. With the default value of zero, a control-byte read would return the same bits as a forced-low data line. The non-zero value makes a 0x31 read distinguishable from an undefined command. All other parameters keep their default values. The default 32-entry RAM and the default bit positions put every RAM address, write commit, time field and status flag clear within reach of random and directed frames.

// File: rtl/rtc_serial_pkg.sv
package rtc_serial_pkg;

  typedef enum logic [2:0] {
    CLS_RAM  = 3'd0,
    CLS_STAT = 3'd1,
    CLS_CTRL = 3'd2,
    CLS_TIME = 3'd3,
    CLS_WRAM = 3'd4,
    CLS_WCLR = 3'd5,
    CLS_NONE = 3'd6
  } cmd_cls_e;

  localparam logic [7:0] STATUS_CLR_MASK = 8'h18;
  localparam int unsigned CLR_REQ_BIT    = 2;

  function automatic cmd_cls_e classify(input logic [7:0] c);
    cmd_cls_e r;
    if (c[7:5] == 3'b000)      r = CLS_RAM;
    else if (c[7:4] == 4'h2)   r = CLS_TIME;
    else if (c == 8'h30)       r = CLS_STAT;
    else if (c == 8'h31)       r = CLS_CTRL;
    else if (c[7:5] == 3'b100) r = CLS_WRAM;
    else if (c == 8'hB1)       r = CLS_WCLR;
    else                       r = CLS_NONE;
    return r;
  endfunction

  function automatic logic is_read(input cmd_cls_e c);
    return (c == CLS_RAM) || (c == CLS_STAT) || (c == CLS_CTRL) || (c == CLS_TIME);
  endfunction

  function automatic logic [7:0] to_bcd(input logic [7:0] v);
    logic [7:0] t;
    logic [7:0] u;
    t = v / 8'd10;
    u = v % 8'd10;
    return {t[3:0], u[3:0]};
  endfunction

  function automatic logic [7:0] ram_default(input int unsigned i);
    logic [7:0] k;
    k = 8'(i);
    return (k * 8'h1D) ^ 8'h5A;
  endfunction

endpackage

// File: rtl/rtc_frame_ctrl.sv
module rtc_frame_ctrl
  import rtc_serial_pkg::*;
#(
  parameter int unsigned SEL_BIT = 0,
  parameter int unsigned CLK_BIT = 1,
  parameter int unsigned DAT_BIT = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [7:0] ctrl_i,
  input  cmd_cls_e   cls_i,
  input  logic       ret_bit_i,
  output logic [7:0] ctrl_o,
  output logic [7:0] cmd_o,
  output logic [2:0] bit_idx_o,
  output logic       data_ph_o,
  output logic       commit_o,
  output logic [7:0] commit_val_o,
  output logic [7:0] shift_o
);

  localparam int unsigned PW        = 5;
  localparam logic [PW-1:0] CMD_END = PW'(8);
  localparam logic [PW-1:0] DAT_END = PW'(16);
  localparam logic [PW-1:0] LAST    = PW'(15);

  logic [7:0]    ctrl_q, ctrl_nx;
  logic          idle_q;
  logic [PW-1:0] phase_q, cur, phase_nx;
  logic [7:0]    cmd_q, val_q, val_nx, shift_q;
  logic          sel, fall, step, din, rd_cls;

  always_comb begin
    sel      = ctrl_i[SEL_BIT];
    din      = ctrl_i[DAT_BIT];
    fall     = ctrl_q[CLK_BIT] & ~ctrl_i[CLK_BIT];
    cur      = idle_q ? '0 : phase_q;
    step     = wr_en_i & sel & fall;
    rd_cls   = is_read(cls_i);
    data_ph_o = step && (cur >= CMD_END) && (cur < DAT_END);
    bit_idx_o = 3'd7 - cur[2:0];
    val_nx   = {val_q[6:0], din};
    phase_nx = (fall && cur != DAT_END) ? cur + PW'(1) : cur;
    ctrl_nx  = ctrl_i;
    if (data_ph_o) begin
      if (rd_cls)                ctrl_nx[DAT_BIT] = ret_bit_i;
      else if (cls_i == CLS_NONE) ctrl_nx[DAT_BIT] = 1'b0;
    end
  end

  assign commit_o     = step && (cur == LAST);
  assign commit_val_o = val_nx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      idle_q  <= 1'b1;
      phase_q <= '0;
      cmd_q   <= '0;
      val_q   <= '0;
      shift_q <= '0;
    end else if (wr_en_i) begin
      ctrl_q <= ctrl_nx;
      if (!sel) begin
        idle_q  <= 1'b1;
        phase_q <= '0;
        cmd_q   <= '0;
        val_q   <= '0;
      end else begin
        idle_q  <= 1'b0;
        phase_q <= phase_nx;
        if (step && cur < CMD_END) cmd_q <= {cmd_q[6:0], din};
        if (data_ph_o)             val_q <= val_nx;
      end
      if (data_ph_o && rd_cls) shift_q <= {shift_q[6:0], ret_bit_i};
    end
  end

  assign ctrl_o  = ctrl_q;
  assign cmd_o   = cmd_q;
  assign shift_o = shift_q;

  AST_DESEL_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !ctrl_i[SEL_BIT]) |=> (idle_q && cmd_q == 8'h00 && val_q == 8'h00)); // R9
  AST_NO_EDGE_NO_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && ctrl_i[SEL_BIT] && !idle_q && !(ctrl_q[CLK_BIT] && !ctrl_i[CLK_BIT]))
      |=> ($stable(phase_q) && $stable(cmd_q) && $stable(val_q))); // R2
  AST_QUIET_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(ctrl_q) && $stable(phase_q) && $stable(idle_q) && $stable(shift_q))); // R2
  AST_PHASE_CAPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q <= DAT_END); // R12

endmodule

// File: rtl/rtc_read_mux.sv
module rtc_read_mux
  import rtc_serial_pkg::*;
#(
  parameter logic [7:0] CTRL_INIT = 8'h00
) (
  input  cmd_cls_e   cls_i,
  input  logic [3:0] sub_i,
  input  logic [2:0] bit_idx_i,
  input  logic [7:0] ram_byte_i,
  input  logic [7:0] status_i,
  input  logic [5:0] sec_i,
  input  logic [5:0] min_i,
  input  logic [4:0] hour_i,
  input  logic [4:0] mday_i,
  input  logic [3:0] mon_i,
  input  logic [7:0] year_i,
  output logic       ret_bit_o
);

  logic [7:0] time_byte, sel_byte;

  always_comb begin
    unique case (sub_i)
      4'h0:    time_byte = to_bcd(8'(sec_i));
      4'h1:    time_byte = to_bcd(8'(min_i));
      4'h2:    time_byte = to_bcd(8'(hour_i));
      4'h4:    time_byte = to_bcd(8'(mday_i));
      4'h5:    time_byte = to_bcd(8'(mon_i) + 8'd1);
      4'h6:    time_byte = to_bcd(year_i - 8'd100);
      default: time_byte = 8'h00;
    endcase
    unique case (cls_i)
      CLS_RAM:  sel_byte = ram_byte_i;
      CLS_STAT: sel_byte = status_i;
      CLS_CTRL: sel_byte = CTRL_INIT;
      CLS_TIME: sel_byte = time_byte;
      default:  sel_byte = 8'h00;
    endcase
    ret_bit_o = sel_byte[bit_idx_i];
  end

endmodule

// File: rtl/rtc_store.sv
module rtc_store
  import rtc_serial_pkg::*;
#(
  parameter int unsigned RAM_DEPTH   = 32,
  parameter logic [7:0]  STATUS_INIT = 8'h90,
  localparam int unsigned ADDR_W     = $clog2(RAM_DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  cmd_cls_e          cls_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        val_i,
  output logic [7:0]        ram_byte_o,
  output logic [7:0]        status_o,
  output logic              flag_clr_o
);

  logic [7:0] mem_q [RAM_DEPTH];
  logic [7:0] status_q;
  logic       flag_q;
  logic       wr_hit, clr_hit;

  assign wr_hit  = commit_i && (cls_i == CLS_WRAM);
  assign clr_hit = commit_i && (cls_i == CLS_WCLR) && val_i[CLR_REQ_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < RAM_DEPTH; i++) mem_q[i] <= ram_default(i);
    end else if (wr_hit) begin
      mem_q[addr_i] <= val_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= STATUS_INIT;
      flag_q   <= 1'b0;
    end else begin
      flag_q <= clr_hit;
      if (clr_hit) status_q <= status_q & ~STATUS_CLR_MASK;
    end
  end

  assign ram_byte_o = mem_q[addr_i];
  assign status_o   = status_q;
  assign flag_clr_o = flag_q;

  for (genvar g = 0; g < RAM_DEPTH; g++) begin : g_ent_chk
    AST_RAM_ONLY_ON_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr_hit && addr_i == ADDR_W'(g)) |=> $stable(mem_q[g])); // R9
  end

  AST_FLAG_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_clr_o |=> !flag_clr_o); // R8
  AST_FLAG_FROM_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_clr_o) |-> $past(commit_i)); // R8
  AST_STATUS_NEVER_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(status_q)); // R8

endmodule

// File: rtl/rtc_serial_slave.sv
module rtc_serial_slave
  import rtc_serial_pkg::*;
#(
  parameter int unsigned RAM_DEPTH   = 32,
  parameter logic [7:0]  STATUS_INIT = 8'h90,
  parameter logic [7:0]  CTRL_INIT   = 8'h00,
  parameter int unsigned SEL_BIT     = 0,
  parameter int unsigned CLK_BIT     = 1,
  parameter int unsigned DAT_BIT     = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [7:0] ctrl_i,
  input  logic [5:0] sec_i,
  input  logic [5:0] min_i,
  input  logic [4:0] hour_i,
  input  logic [4:0] mday_i,
  input  logic [3:0] mon_i,
  input  logic [7:0] year_i,
  output logic [7:0] ctrl_o,
  output logic       dout_o,
  output logic       flag_clr_o,
  output logic [7:0] rd_shift_o
);

  localparam int unsigned ADDR_W = $clog2(RAM_DEPTH);

  cmd_cls_e   cls;
  logic [7:0] cmd, commit_val, ram_byte, status;
  logic [2:0] bit_idx;
  logic       data_ph, commit, ret_bit;

  assign cls = classify(cmd);

  rtc_frame_ctrl #(
    .SEL_BIT (SEL_BIT),
    .CLK_BIT (CLK_BIT),
    .DAT_BIT (DAT_BIT)
  ) u_frame (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .ctrl_i       (ctrl_i),
    .cls_i        (cls),
    .ret_bit_i    (ret_bit),
    .ctrl_o       (ctrl_o),
    .cmd_o        (cmd),
    .bit_idx_o    (bit_idx),
    .data_ph_o    (data_ph),
    .commit_o     (commit),
    .commit_val_o (commit_val),
    .shift_o      (rd_shift_o)
  );

  rtc_read_mux #(
    .CTRL_INIT (CTRL_INIT)
  ) u_mux (
    .cls_i      (cls),
    .sub_i      (cmd[3:0]),
    .bit_idx_i  (bit_idx),
    .ram_byte_i (ram_byte),
    .status_i   (status),
    .sec_i      (sec_i),
    .min_i      (min_i),
    .hour_i     (hour_i),
    .mday_i     (mday_i),
    .mon_i      (mon_i),
    .year_i     (year_i),
    .ret_bit_o  (ret_bit)
  );

  rtc_store #(
    .RAM_DEPTH   (RAM_DEPTH),
    .STATUS_INIT (STATUS_INIT)
  ) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .commit_i   (commit),
    .cls_i      (cls),
    .addr_i     (cmd[ADDR_W-1:0]),
    .val_i      (commit_val),
    .ram_byte_o (ram_byte),
    .status_o   (status),
    .flag_clr_o (flag_clr_o)
  );

  assign dout_o = ctrl_o[DAT_BIT];

  AST_UNDEF_DRIVES_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_ph && cls == CLS_NONE) |=> !ctrl_o[DAT_BIT]); // R10
  AST_WRITE_REFLECTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_ph && cls == CLS_WRAM) |=> (ctrl_o[DAT_BIT] == $past(ctrl_i[DAT_BIT]))); // R7
  AST_NO_COMMIT_OFF_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |-> (wr_en_i && ctrl_i[SEL_BIT])); // R9

endmodule

// File: tb/rtc_serial_slave_test.sv
module rtc_serial_slave_test;

  localparam logic [7:0] CTRL_VAL = 8'h6C;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] ctrl = 8'h00;
  logic [5:0] sec = 6'd0, mn = 6'd0;
  logic [4:0] hr = 5'd0, md = 5'd1;
  logic [3:0] mo = 4'd0;
  logic [7:0] yr = 8'd100;
  logic [7:0] ctrl_o, rd_shift;
  logic       dout, flag_clr;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] m_ram [32];
  logic [7:0] m_status;
  logic [7:0] m_shift;

  always #5 clk = ~clk;

  rtc_serial_slave #(.CTRL_INIT(CTRL_VAL)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .ctrl_i(ctrl),
    .sec_i(sec), .min_i(mn), .hour_i(hr), .mday_i(md), .mon_i(mo), .year_i(yr),
    .ctrl_o(ctrl_o), .dout_o(dout), .flag_clr_o(flag_clr), .rd_shift_o(rd_shift)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic logic rd_cmd(input logic [7:0] c);
    return (c <= 8'h2F) || c == 8'h30 || c == 8'h31;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [7:0] c);
    if (c <= 8'h1F) return m_ram[c[4:0]];
    if (c == 8'h30) return m_status;
    if (c == 8'h31) return CTRL_VAL;
    case (c)
      8'h20: return bcd(int'(sec));
      8'h21: return bcd(int'(mn));
      8'h22: return bcd(int'(hr));
      8'h24: return bcd(int'(md));
      8'h25: return bcd(int'(mo) + 1);
      8'h26: return bcd(int'(yr) - 100);
      default: return 8'h00;
    endcase
  endfunction

  // one write, outputs valid on return
  task automatic wr(input logic [7:0] b);
    @(negedge clk);
    wr_en = 1'b1;
    ctrl  = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic frame(input logic [7:0] c, input logic [7:0] v, input int edges,
                       input logic glitch, output logic [7:0] got, output logic flag_seen);
    logic d;
    got = 8'h00;
    flag_seen = 1'b0;
    wr(8'h01);
    for (int i = 0; i < edges; i++) begin
      d = (i < 8) ? c[7-i] : ((i < 16) ? v[15-i] : 1'b1);
      wr({5'b0, d, 2'b11});
      if (glitch) wr({5'b0, ~d, 2'b11});
      wr({5'b0, d, 2'b01});
      if (i >= 8 && i < 16) got[15-i] = ctrl_o[2];
      if (i == 15) flag_seen = flag_clr;
      if (i >= 16) chk(ctrl_o[2] == 1'b1, "R12", ctrl_o[2], 1);
    end
    wr(8'h00);
  endtask

  // full frame with model update and checks
  task automatic run(input logic [7:0] c, input logic [7:0] v, input logic glitch, input string req);
    logic [7:0] got, exp;
    logic fl, exp_fl;
    if (rd_cmd(c))                  exp = exp_rd(c);
    else if (c >= 8'h80 && c <= 8'h9F) exp = v;
    else if (c == 8'hB1)             exp = v;
    else                             exp = 8'h00;
    if (rd_cmd(c)) m_shift = exp;
    exp_fl = (c == 8'hB1) && v[2];
    frame(c, v, 16, glitch, got, fl);
    chk(got == exp, req, got, exp);
    chk(fl == exp_fl, "R8", fl, exp_fl);
    chk(rd_shift == m_shift, "R11", rd_shift, m_shift);
    if (c >= 8'h80 && c <= 8'h9F) m_ram[c[4:0]] = v;
    if (exp_fl) m_status = m_status & ~8'h18;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] got, c, v;
    logic fl;
    int pick;
    void'($urandom(32'd2024));
    for (int i = 0; i < 32; i++) m_ram[i] = 8'((i * 8'h1D) ^ 8'h5A);
    m_status = 8'h90;
    m_shift = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ctrl_o == 8'h00 && !dout, "R1", ctrl_o, 0);
    chk(!flag_clr && rd_shift == 8'h00, "R1", {flag_clr, rd_shift}, 0);

    // R2: no write strobe, nothing moves
    ctrl = 8'hFF;
    repeat (4) @(negedge clk);
    chk(ctrl_o == 8'h00, "R2", ctrl_o, 0);

    run(8'h30, 8'h00, 1'b0, "R1 status");
    run(8'h31, 8'h00, 1'b0, "R5 control");
    for (int a = 0; a < 32; a++) run(8'(a), 8'h00, 1'b0, "R4 default image");
    run(8'h30, 8'h00, 1'b1, "R2 clock-high toggles ignored");

    // R8 without request bit
    run(8'hB1, 8'hFB, 1'b0, "R8 no clear");
    run(8'h30, 8'h00, 1'b0, "R8 status kept");
    run(8'hB1, 8'h04, 1'b0, "R8 clear");
    run(8'h30, 8'h00, 1'b0, "R8 status cleared");
    wr(8'h00);
    chk(!flag_clr, "R8 pulse width", flag_clr, 0);

    // R9 abort
    frame(8'h8A, 8'h33, 12, 1'b0, got, fl);
    run(8'h0A, 8'h00, 1'b0, "R9 aborted write");
    frame(8'h8B, 8'h00, 4, 1'b0, got, fl);
    run(8'h0B, 8'h00, 1'b0, "R9 abort in command");

    // R12 extra edges after the frame
    frame(8'h85, 8'hC3, 19, 1'b0, got, fl);
    m_ram[5] = 8'hC3;
    run(8'h05, 8'h00, 1'b0, "R12 read after overrun");

    // R10 undefined commands
    run(8'h40, 8'hFF, 1'b0, "R10");
    run(8'hB0, 8'hFF, 1'b0, "R10");
    run(8'h23, 8'hFF, 1'b0, "R6 unlisted time");
    run(8'h2F, 8'hFF, 1'b0, "R6 unlisted time");

    // random mix
    for (int n = 0; n < 120; n++) begin
      sec = 6'($urandom % 60);
      mn  = 6'($urandom % 60);
      hr  = 5'($urandom % 24);
      md  = 5'(1 + $urandom % 31);
      mo  = 4'($urandom % 12);
      yr  = 8'(100 + $urandom % 100);
      pick = int'($urandom % 5);
      case (pick)
        0: c = 8'($urandom % 32);
        1: c = 8'h20 + 8'($urandom % 16);
        2: c = 8'h80 + 8'($urandom % 32);
        3: c = ($urandom % 2) ? 8'h30 : 8'h31;
        default: c = 8'($urandom);
      endcase
      v = 8'($urandom);
      if (c == 8'hB1) v[2] = 1'b0;
      run(c, v, n[0], (pick == 1) ? "R6 time" : (pick == 2) ? "R7 write" : "R3 frame");
    end
    for (int a = 0; a < 32; a++) run(8'(a), 8'h00, 1'b0, "R7 readback");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule